// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and brings the memory from power-on to a usable state. Out of reset it holds clock enable low for a programmable number of microseconds, with the wait converted to cycles from a clock-frequency parameter. It then raises clock enable under a NOP and issues a fixed command sequence: precharge-all, extended register write (DLL on), main register write with DLL reset, precharge-all, a wait until the DLL has had its lock window, a programmable number of auto-refreshes, and a final main register write with the DLL-reset bit cleared. Each step waits out its own spacing (precharge period, refresh period, register-write period) before the next command.

Burst length code, burst type and read latency code are taken from inputs at each main register write. When initialization is complete, `init_done_o` goes high. After a change of clock frequency, pulsing `restart_i` while done re-runs the DLL part of the sequence. This re-run skips the extended register write and clears `init_done_o` until the final register write has settled. All pins are driven from flops. Every cycle that carries no command drives NOP.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_ni` is low: `cke_o` is 0, the command pins carry NOP (`cs_no`=0, `ras_no`=1, `cas_no`=1, `we_no`=1), `ba_o` and `addr_o` are 0, and `init_done_o` is 0.
- R2: Let PWR = WAIT_US*CLK_MHZ, and number the cycles 1, 2, ... from the first clock edge after reset release. `cke_o` stays 0 through cycle PWR and rises in cycle PWR+1, which carries NOP. While `cke_o` is 0, only NOP is driven. Once high, `cke_o` never falls again until reset.
- R3: Command timing. Precharge-all comes in cycle PWR+2. The extended write follows T_RP cycles later. The DLL-reset write follows T_MRD cycles after that, and a precharge-all T_MRD cycles after it. The first auto-refresh comes DLL_LOCK_CYC cycles after the DLL-reset write (when that exceeds T_MRD+T_RP). REF_NUM refreshes follow, T_RFC apart, and the final main write comes T_RFC after the last refresh. No refresh is issued within DLL_LOCK_CYC cycles of a DLL-reset write.
- R4: Command codes on {cs_no,ras_no,cas_no,we_no}: NOP 0111, precharge-all 0010 with `addr_o[10]`=1, auto-refresh 0001, register write 0000.
- R5: The extended register write drives `ba_o`=1 and `addr_o`=0. A0 low enables the DLL, and all other bits are 0.
- R6: A main register write drives `ba_o`=0, `addr_o[2:0]`=`bl_code_i`, `addr_o[3]`=`burst_ilv_i`, `addr_o[6:4]`=`cl_code_i`, and `addr_o[8]`=1 on the DLL-reset write and 0 on the final write. All other address bits are 0.
- R7: `init_done_o` rises exactly T_MRD cycles after the final main register write. It then stays high with only NOP driven until a restart.
- R8: A `restart_i` pulse sampled while done drops `init_done_o` two cycles later, in the same cycle as a precharge-all. The sequence then continues with the DLL-reset write, precharge-all, lock wait, REF_NUM refreshes and final write, using the R3 spacing and with no extended write.
- R9: `restart_i` has no effect while initialization is in progress.
- R10: A non-NOP command is always followed by a NOP cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Re-run DLL reset and lock after a frequency change |
| bl_code_i | input | 3 | Burst length code for the main register |
| burst_ilv_i | input | 1 | Burst type, 1 = interleaved |
| cl_code_i | input | 3 | Read latency code for the main register |
| cke_o | output | 1 | Clock enable to the memory |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Initialization complete |

## Verification
The bound checker checks on every cycle that clock enable never falls once raised and that only NOP is driven while it is low or while done. It also checks that each command is followed by a NOP, that precharges carry A10, and that extended writes carry an all-zero address. Using its own cycle counters, it checks that no refresh comes inside the DLL lock window and that done rises exactly T_MRD after a final write with A8 clear. The exact cycle of each command, the mode field values taken from the inputs, the shortened restart sequence, and the fact that restart is ignored mid-sequence are shown only by the bench's scenarios.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_CKE,
    ST_PRE_A,
    ST_EMRS,
    ST_MRS_DLL,
    ST_PRE_B,
    ST_LOCK,
    ST_REF,
    ST_MRS_FIN,
    ST_DONE
  } state_e;

  typedef struct packed {
    cmd_e cmd;
    logic ext;      // extended register target
    logic dll_rst;  // set A8 on main register write
    logic cke;
  } req_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  function automatic pins_t cmd_pins(cmd_e c);
    pins_t p;
    case (c)
      CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= W'(RST_VAL);
    else if (load_i)            cnt_o <= val_i;
    else if (cnt_o != '0)       cnt_o <= cnt_o - W'(1);
  end

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int unsigned GW      = 16,
  parameter int unsigned LW      = 8,
  parameter int unsigned GAP_RP  = 4,
  parameter int unsigned GAP_RFC = 15,
  parameter int unsigned GAP_MRD = 2,
  parameter int unsigned REF_NUM = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [GW-1:0] gap_cnt_i,
  input  logic [LW-1:0] lock_cnt_i,
  output logic          gap_load_o,
  output logic [GW-1:0] gap_val_o,
  output logic          lock_load_o,
  output req_t          req_o,
  output logic          done_o
);

  localparam int unsigned RW = $clog2(REF_NUM + 1);

  state_e        state_q, state_d, step_next;
  cmd_e          step_cmd;
  logic [GW-1:0] step_gap;
  logic          is_step;
  logic          busy_q, busy_d;
  logic          relock_q, relock_d;
  logic [RW-1:0] ref_q, ref_d;
  logic          ref_last;

  assign ref_last = (ref_q == RW'(REF_NUM - 1));
  assign done_o   = (state_q == ST_DONE);

  always_comb begin
    state_d     = state_q;
    busy_d      = busy_q;
    relock_d    = relock_q;
    ref_d       = ref_q;
    gap_load_o  = 1'b0;
    gap_val_o   = '0;
    lock_load_o = 1'b0;
    req_o.cmd     = CMD_NOP;
    req_o.ext     = 1'b0;
    req_o.dll_rst = 1'b0;
    req_o.cke     = 1'b1;
    step_cmd    = CMD_NOP;
    step_gap    = '0;
    step_next   = state_q;
    is_step     = 1'b1;

    unique case (state_q)
      ST_PWR: begin
        is_step   = 1'b0;
        req_o.cke = 1'b0;
        if (gap_cnt_i <= GW'(1)) state_d = ST_CKE;
      end
      ST_CKE: begin
        is_step = 1'b0;
        state_d = ST_PRE_A;
        busy_d  = 1'b0;
      end
      ST_PRE_A: begin
        step_cmd  = CMD_PRE;
        step_gap  = GW'(GAP_RP - 1);
        step_next = relock_q ? ST_MRS_DLL : ST_EMRS;
      end
      ST_EMRS: begin
        step_cmd  = CMD_MRS;
        step_gap  = GW'(GAP_MRD - 1);
        step_next = ST_MRS_DLL;
      end
      ST_MRS_DLL: begin
        step_cmd  = CMD_MRS;
        step_gap  = GW'(GAP_MRD - 1);
        step_next = ST_PRE_B;
      end
      ST_PRE_B: begin
        step_cmd  = CMD_PRE;
        step_gap  = GW'(GAP_RP - 1);
        step_next = ST_LOCK;
      end
      ST_LOCK: begin
        is_step = 1'b0;
        if (lock_cnt_i <= LW'(1)) state_d = ST_REF;
      end
      ST_REF: begin
        step_cmd  = CMD_REF;
        step_gap  = GW'(GAP_RFC - 1);
        step_next = ref_last ? ST_MRS_FIN : ST_REF;
      end
      ST_MRS_FIN: begin
        step_cmd  = CMD_MRS;
        step_gap  = GW'(GAP_MRD - 1);
        step_next = ST_DONE;
      end
      ST_DONE: begin
        is_step = 1'b0;
        if (restart_i) begin
          state_d  = ST_PRE_A;
          relock_d = 1'b1;
        end
      end
      default: begin
        is_step = 1'b0;
        state_d = ST_PWR;
      end
    endcase

    if (is_step) begin
      if (!busy_q) begin
        req_o.cmd     = step_cmd;
        req_o.ext     = (state_q == ST_EMRS);
        req_o.dll_rst = (state_q == ST_MRS_DLL);
        gap_load_o    = 1'b1;
        gap_val_o     = step_gap;
        lock_load_o   = (state_q == ST_MRS_DLL);
        busy_d        = 1'b1;
      end else if (gap_cnt_i <= GW'(1)) begin
        busy_d  = 1'b0;
        state_d = step_next;
        if (state_q == ST_REF)     ref_d    = ref_last ? '0 : ref_q + RW'(1);
        if (state_q == ST_MRS_FIN) relock_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_PWR;
      busy_q   <= 1'b0;
      relock_q <= 1'b0;
      ref_q    <= '0;
    end else begin
      state_q  <= state_d;
      busy_q   <= busy_d;
      relock_q <= relock_d;
      ref_q    <= ref_d;
    end
  end

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  req_t              req_i,
  input  logic              done_i,
  input  logic [2:0]        bl_code_i,
  input  logic              burst_ilv_i,
  input  logic [2:0]        cl_code_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  pins_t             pins_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    pins_d = cmd_pins(req_i.cmd);
    ba_d   = '0;
    addr_d = '0;
    case (req_i.cmd)
      CMD_PRE: addr_d[10] = 1'b1;
      CMD_MRS: begin
        if (req_i.ext) begin
          ba_d = BA_W'(1);  // DLL enable = A0 low, drive strength normal
        end else begin
          addr_d[2:0] = bl_code_i;
          addr_d[3]   = burst_ilv_i;
          addr_d[6:4] = cl_code_i;
          addr_d[8]   = req_i.dll_rst;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o       <= 1'b0;
      cs_no       <= 1'b0;
      ras_no      <= 1'b1;
      cas_no      <= 1'b1;
      we_no       <= 1'b1;
      ba_o        <= '0;
      addr_o      <= '0;
      init_done_o <= 1'b0;
    end else begin
      cke_o       <= req_i.cke;
      cs_no       <= pins_d.cs_n;
      ras_no      <= pins_d.ras_n;
      cas_no      <= pins_d.cas_n;
      we_no       <= pins_d.we_n;
      ba_o        <= ba_d;
      addr_o      <= addr_d;
      init_done_o <= done_i;
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 250,
  parameter int unsigned WAIT_US      = 200,
  parameter int unsigned T_RP         = 4,
  parameter int unsigned T_RFC        = 15,
  parameter int unsigned T_MRD        = 2,
  parameter int unsigned DLL_LOCK_CYC = 200,
  parameter int unsigned REF_NUM      = 2,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned BA_W         = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [2:0]        bl_code_i,
  input  logic              burst_ilv_i,
  input  logic [2:0]        cl_code_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int unsigned PWR_CYC  = WAIT_US * CLK_MHZ;
  localparam int unsigned GAP_RP   = (T_RP  < 2) ? 2 : T_RP;
  localparam int unsigned GAP_RFC  = (T_RFC < 2) ? 2 : T_RFC;
  localparam int unsigned GAP_MRD  = (T_MRD < 2) ? 2 : T_MRD;
  localparam int unsigned MAX_A    = (GAP_RP > GAP_RFC) ? GAP_RP : GAP_RFC;
  localparam int unsigned MAX_B    = (MAX_A > GAP_MRD) ? MAX_A : GAP_MRD;
  localparam int unsigned STEP_MAX = (MAX_B > PWR_CYC) ? MAX_B : PWR_CYC;
  localparam int unsigned GW       = $clog2(STEP_MAX + 1);
  localparam int unsigned LW       = $clog2(DLL_LOCK_CYC + 1);
  localparam int unsigned LOCK_LD  = (DLL_LOCK_CYC < 1) ? 0 : DLL_LOCK_CYC - 1;

  logic          gap_load, lock_load, done;
  logic [GW-1:0] gap_val, gap_cnt;
  logic [LW-1:0] lock_cnt;
  req_t          req;

  ddr_init_timer #(.W(GW), .RST_VAL(PWR_CYC)) i_gap_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gap_load),
    .val_i  (gap_val),
    .cnt_o  (gap_cnt)
  );

  ddr_init_timer #(.W(LW), .RST_VAL(0)) i_lock_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (lock_load),
    .val_i  (LW'(LOCK_LD)),
    .cnt_o  (lock_cnt)
  );

  ddr_init_fsm #(
    .GW(GW), .LW(LW), .GAP_RP(GAP_RP), .GAP_RFC(GAP_RFC),
    .GAP_MRD(GAP_MRD), .REF_NUM(REF_NUM)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_i),
    .gap_cnt_i   (gap_cnt),
    .lock_cnt_i  (lock_cnt),
    .gap_load_o  (gap_load),
    .gap_val_o   (gap_val),
    .lock_load_o (lock_load),
    .req_o       (req),
    .done_o      (done)
  );

  ddr_init_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) i_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .done_i      (done),
    .bl_code_i   (bl_code_i),
    .burst_ilv_i (burst_ilv_i),
    .cl_code_i   (cl_code_i),
    .cke_o       (cke_o),
    .cs_no       (cs_no),
    .ras_no      (ras_no),
    .cas_no      (cas_no),
    .we_no       (we_no),
    .ba_o        (ba_o),
    .addr_o      (addr_o),
    .init_done_o (init_done_o)
  );

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int unsigned T_MRD        = 2,
  parameter int unsigned DLL_LOCK_CYC = 200,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned BA_W         = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              init_done_o
);

  localparam int unsigned DW = $clog2(DLL_LOCK_CYC + 2);
  localparam int unsigned MW = $clog2(T_MRD + 3);

  logic is_nop, is_pre, is_ref, is_mrs, is_dll;
  assign is_nop = !cs_no &&  ras_no &&  cas_no &&  we_no;
  assign is_pre = !cs_no && !ras_no &&  cas_no && !we_no;
  assign is_ref = !cs_no && !ras_no && !cas_no &&  we_no;
  assign is_mrs = !cs_no && !ras_no && !cas_no && !we_no;
  assign is_dll = is_mrs && (ba_o == '0) && addr_o[8];

  logic [DW-1:0] since_dll;
  logic          dll_seen;
  logic [MW-1:0] since_mrs;
  logic          last_dll;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_dll <= '0;
      dll_seen  <= 1'b0;
      since_mrs <= '0;
      last_dll  <= 1'b0;
    end else begin
      if (is_dll) begin
        since_dll <= DW'(1);
        dll_seen  <= 1'b1;
      end else if (since_dll < DW'(DLL_LOCK_CYC)) begin
        since_dll <= since_dll + DW'(1);
      end
      if (is_mrs && (ba_o == '0)) begin
        since_mrs <= MW'(1);
        last_dll  <= addr_o[8];
      end else if (since_mrs < MW'(T_MRD + 1)) begin
        since_mrs <= since_mrs + MW'(1);
      end
    end
  end

  assert_cke_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  assert_nop_cke_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> is_nop);

  assert_cmd_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_nop |=> is_nop);

  assert_pre_a10_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> addr_o[10]);

  assert_ext_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && ba_o == BA_W'(1)) |-> (addr_o == '0));

  assert_lock_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref |-> (dll_seen && since_dll >= DW'(DLL_LOCK_CYC)));

  assert_done_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> is_nop);

  assert_done_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> (since_mrs == MW'(T_MRD) && !last_dll));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .T_MRD(T_MRD), .DLL_LOCK_CYC(DLL_LOCK_CYC), .ADDR_W(ADDR_W), .BA_W(BA_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cke_o       (cke_o),
  .cs_no       (cs_no),
  .ras_no      (ras_no),
  .cas_no      (cas_no),
  .we_no       (we_no),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .init_done_o (init_done_o)
);

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;

  localparam int CLK_MHZ = 50;
  localparam int WAIT_US = 2;
  localparam int PWR     = CLK_MHZ * WAIT_US;
  localparam int T_RP    = 4;
  localparam int T_RFC   = 15;
  localparam int T_MRD   = 2;
  localparam int LOCK    = 200;
  localparam int REF_NUM = 2;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        restart = 1'b0;
  logic [2:0]  bl_code = 3'b010;
  logic        ilv = 1'b0;
  logic [2:0]  cl_code = 3'b010;
  logic        cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0]  ba;
  logic [11:0] addr;

  always #10 clk = ~clk;

  ddr_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US)) i_ddr_init_seq (
    .clk_i(clk), .rst_ni(rst_ni), .restart_i(restart),
    .bl_code_i(bl_code), .burst_ilv_i(ilv), .cl_code_i(cl_code),
    .cke_o(cke), .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .ba_o(ba), .addr_o(addr), .init_done_o(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // monitor: sample index n = clock edges since reset release
  int         n_q = 0;
  int         ev_cnt = 0;
  int         ev_n [0:31];
  logic [3:0] ev_c [0:31];
  logic [1:0] ev_ba [0:31];
  logic [11:0] ev_a [0:31];
  int         cke_n = 0;
  bit         cke_fell = 1'b0;
  bit         cke_prev = 1'b0;
  int         done_rise_n = 0;
  int         done_fall_n = 0;
  bit         done_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      n_q = n_q + 1;
      if ({cs_n, ras_n, cas_n, we_n} != C_NOP && ev_cnt < 32) begin
        ev_n[ev_cnt]  = n_q;
        ev_c[ev_cnt]  = {cs_n, ras_n, cas_n, we_n};
        ev_ba[ev_cnt] = ba;
        ev_a[ev_cnt]  = addr;
        ev_cnt = ev_cnt + 1;
      end
      if (cke && cke_n == 0) cke_n = n_q;
      if (!cke && cke_prev) cke_fell = 1'b1;
      cke_prev = cke;
      if (done && !done_prev) done_rise_n = n_q;
      if (!done && done_prev) done_fall_n = n_q;
      done_prev = done;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_ev(input string tag, input int idx, input int n,
                        input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
    chk($sformatf("R3 cycle of command %0d", idx), ev_n[idx], n);
    chk($sformatf("%s code of command %0d", tag, idx), ev_c[idx], c);
    chk($sformatf("%s bank of command %0d", tag, idx), ev_ba[idx], b);
    chk($sformatf("%s addr of command %0d", tag, idx), ev_a[idx], a);
  endtask

  function automatic logic [11:0] mode_word(input logic dll);
    return {3'b000, dll, 1'b0, cl_code, ilv, bl_code};
  endfunction

  // checks the logged sequence from index 0; returns cycle of final write
  task automatic chk_seq(input int first_n, input bit with_ext, output int fin_n);
    int idx = 0;
    int t = first_n;
    int dll_n;
    chk_ev("R4", idx, t, C_PRE, 2'd0, 12'h400); idx++; t += T_RP;
    if (with_ext) begin
      chk_ev("R5", idx, t, C_MRS, 2'd1, 12'h000); idx++; t += T_MRD;
    end
    chk_ev("R6", idx, t, C_MRS, 2'd0, mode_word(1'b1)); idx++;
    dll_n = t; t += T_MRD;
    chk_ev("R4", idx, t, C_PRE, 2'd0, 12'h400); idx++;
    t = dll_n + LOCK;
    for (int r = 0; r < REF_NUM; r++) begin
      chk_ev("R4", idx, t, C_REF, 2'd0, 12'h000); idx++; t += T_RFC;
    end
    chk_ev("R6", idx, t, C_MRS, 2'd0, mode_word(1'b0)); idx++;
    chk("R3 command count", ev_cnt, idx);
    fin_n = t;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    n_q = 0; ev_cnt = 0; cke_n = 0; cke_fell = 1'b0; cke_prev = 1'b0;
    done_rise_n = 0; done_fall_n = 0; done_prev = 1'b0;
    #5 rst_ni = 1'b1;
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 cke in reset", cke, 0);
    chk("R1 command in reset", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    chk("R1 bank in reset", ba, 0);
    chk("R1 addr in reset", addr, 0);
    chk("R1 done in reset", done, 0);
  endtask

  task automatic wait_done();
    while (done_rise_n == 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic test_power_up();
    int fin_n;
    bl_code = 3'b010; ilv = 1'b0; cl_code = 3'b010;
    do_reset();
    wait_done();
    chk("R2 cke rise cycle", cke_n, PWR + 1);
    chk("R2 no command before cke", (ev_cnt > 0 && ev_n[0] > cke_n) ? 1 : 0, 1);
    chk_seq(PWR + 2, 1'b1, fin_n);
    chk("R7 done rise cycle", done_rise_n, fin_n + T_MRD);
    repeat (20) @(negedge clk);
    chk("R7 quiet while done", ev_cnt, 1 + 1 + 1 + 1 + REF_NUM + 1);
    chk("R7 done held", done, 1);
    chk("R2 cke never fell", cke_fell, 0);
  endtask

  task automatic test_relock();
    int t0;
    int fin_n;
    ev_cnt = 0;
    @(posedge clk);
    #2 restart = 1'b1;
    t0 = n_q + 1;
    @(posedge clk);
    #2 restart = 1'b0;
    while (ev_cnt < 5 + REF_NUM - 1) @(negedge clk);
    done_rise_n = 0;
    wait_done();
    chk("R8 done fall cycle", done_fall_n, t0 + 2);
    chk_seq(t0 + 2, 1'b0, fin_n);
    chk("R8 done re-rise cycle", done_rise_n, fin_n + T_MRD);
  endtask

  task automatic test_restart_ignored();
    int fin_n;
    bl_code = 3'b011; ilv = 1'b1; cl_code = 3'b011;
    do_reset();
    while (n_q < PWR + 60) @(negedge clk);
    @(posedge clk);
    #2 restart = 1'b1;
    @(posedge clk);
    #2 restart = 1'b0;
    while (n_q < PWR + 20 + LOCK) @(negedge clk);
    #2 restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    wait_done();
    chk("R9 cke rise cycle", cke_n, PWR + 1);
    chk_seq(PWR + 2, 1'b1, fin_n);
    chk("R9 done rise unchanged", done_rise_n, fin_n + T_MRD);
  endtask

  initial begin
    test_reset_state();
    test_power_up();
    test_relock();
    test_restart_ignored();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule